// File: doc/BRIEF.md
# Recency-Windowed Least-Allocated Page Victim Selector

This block picks the entry to replace in one set of a translation buffer whose entries also record where their page's lines sit in the first-level cache. When such an entry is replaced, every cached line of its page has to go as well. The selector therefore prefers a victim page that holds few lines. It only considers pages that have not been used recently, so that a page that was just loaded and is still empty is not thrown out.

Each way of the set has a true-LRU age and a saturating count of the cache lines it currently owns. On a replace request the selector looks only at the `CAND` oldest ways and picks the one with the lowest count. Ties go to the older way. Invalid ways are always taken first. With `CAND=1` the rule is plain LRU, and with `CAND=WAYS` it is plain least-allocated. Evicting the victim's lines is left to the surrounding logic. The surrounding logic then reports the refill through the fill input.

Top module: `lru_lad_victim_sel`

## Requirements
- R1: After reset, all ways are invalid and `victim_vld_o`=0. `victim_o`=0. Way `i` has age `i`, so way 0 is the most recent.
- R2: `victim_vld_o` is high in exactly the cycle after a cycle with `req_i`=1. The `victim_o` it shows is chosen from the state before that edge. When no request was made, `victim_o` holds its value.
- R3: If any way is invalid, the victim is the lowest-indexed invalid way.
- R4: A fill of way `w` marks `w` valid, sets its line count to 0 and makes it the most recent way.
- R5: A touch of way `w` gives `w` age 0. Every way younger than `w` ages by one. Older ways keep their age.
- R6: `line_ins_i[w]` raises way `w`'s count by one, saturating at `MAX_LINES`. `line_evt_i[w]` lowers it by one, saturating at 0. Both together leave it unchanged.
- R7: When all ways are valid, the victim is one of the `CAND` ways with the largest ages, that is age >= `WAYS-CAND`.
- R8: Among those candidates, the way with the smallest count is chosen. On equal counts the way with the larger age is chosen.
- R9: A fill and a touch in the same cycle update recency only for the fill way. A fill also overrides any insert or evict for its own way in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| touch_i | input | 1 | A hit used way `touch_way_i` |
| touch_way_i | input | 3 | Way that was used |
| fill_i | input | 1 | Way `fill_way_i` now holds a new page |
| fill_way_i | input | 3 | Way being refilled |
| line_ins_i | input | 8 | Per-way pulse: one cache line of that page inserted |
| line_evt_i | input | 8 | Per-way pulse: one cache line of that page evicted |
| req_i | input | 1 | Replace request |
| victim_o | output | 3 | Selected victim way |
| victim_vld_o | output | 1 | `victim_o` answers the request of the previous cycle |

## Verification
On every cycle, the assertions check the following:
- the ages stay a permutation of 0..WAYS-1, and a touched way becomes the youngest;
- the counts stay in range, clear on fill and step by one on a lone insert;
- the victim-valid pulse follows exactly one cycle after each request;
- the chosen way is invalid whenever any way is, and otherwise lies inside the oldest-`CAND` window.

The assertions cannot show that the pick is the right one: the lowest count, with ties going to the older way. Nor can they show the fill-over-touch priority or the way saturation affects later choices. Those are shown only by the bench's reference model, which tracks recency as an ordered queue, under directed scenarios and random traffic.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  localparam int unsigned DEF_WAYS      = 8;
  localparam int unsigned DEF_CAND      = 4;
  localparam int unsigned DEF_CNT_W     = 7;
  localparam int unsigned DEF_MAX_LINES = 64;
endpackage

// File: rtl/vsel_age_track.sv
module vsel_age_track #(
  parameter int unsigned WAYS  = vsel_pkg::DEF_WAYS,
  localparam int unsigned AGE_W = $clog2(WAYS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           upd_i,
  input  logic [AGE_W-1:0]               upd_way_i,
  output logic [WAYS-1:0][AGE_W-1:0]     age_o
);
  logic [WAYS-1:0][AGE_W-1:0] age_q;
  logic [AGE_W-1:0]           ref_age;

  assign ref_age = age_q[upd_way_i];
  assign age_o   = age_q;

  for (genvar i = 0; i < WAYS; i++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[i] <= AGE_W'(i);
      end else if (upd_i) begin
        if (upd_way_i == AGE_W'(i))  age_q[i] <= '0;
        else if (age_q[i] < ref_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  // each age value held by exactly one way
  logic [WAYS-1:0][WAYS-1:0] hit_m;
  always_comb begin
    for (int v = 0; v < WAYS; v++)
      for (int i = 0; i < WAYS; i++)
        hit_m[v][i] = (age_q[i] == AGE_W'(v));
  end

  for (genvar v = 0; v < WAYS; v++) begin : g_perm
    assert_age_perm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(hit_m[v]) == 1);
  end

  assert_touch_mru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> age_q[$past(upd_way_i)] == '0);
endmodule

// File: rtl/vsel_line_cnt.sv
module vsel_line_cnt #(
  parameter int unsigned CNT_W     = vsel_pkg::DEF_CNT_W,
  parameter int unsigned MAX_LINES = vsel_pkg::DEF_MAX_LINES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(MAX_LINES);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (clr_i)                          cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
  assign cnt_o = cnt_q;

  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX);
  assert_cnt_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && !dec_i && cnt_q < CMAX) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/vsel_pick.sv
module vsel_pick #(
  parameter int unsigned WAYS  = vsel_pkg::DEF_WAYS,
  parameter int unsigned CAND  = vsel_pkg::DEF_CAND,
  parameter int unsigned CNT_W = vsel_pkg::DEF_CNT_W,
  localparam int unsigned AGE_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][AGE_W-1:0]  age_i,
  input  logic [WAYS-1:0][CNT_W-1:0]  cnt_i,
  output logic [AGE_W-1:0]            way_o
);
  localparam logic [AGE_W-1:0] OLD_MIN = AGE_W'(WAYS - CAND);

  logic [AGE_W-1:0] inv_way, lad_way, best_age;
  logic [CNT_W-1:0] best_cnt;
  logic             found;

  // lowest invalid index
  always_comb begin
    inv_way = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!valid_i[i]) inv_way = AGE_W'(i);
  end

  // least allocated inside the old window, older wins ties
  always_comb begin
    found    = 1'b0;
    lad_way  = '0;
    best_cnt = '0;
    best_age = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (age_i[i] >= OLD_MIN) begin
        if (!found || cnt_i[i] < best_cnt ||
            (cnt_i[i] == best_cnt && age_i[i] > best_age)) begin
          found    = 1'b1;
          lad_way  = AGE_W'(i);
          best_cnt = cnt_i[i];
          best_age = age_i[i];
        end
      end
    end
  end

  assign way_o = (&valid_i) ? lad_way : inv_way;
endmodule

// File: rtl/lru_lad_victim_sel.sv
module lru_lad_victim_sel #(
  parameter int unsigned WAYS      = vsel_pkg::DEF_WAYS,
  parameter int unsigned CAND      = vsel_pkg::DEF_CAND,
  parameter int unsigned CNT_W     = vsel_pkg::DEF_CNT_W,
  parameter int unsigned MAX_LINES = vsel_pkg::DEF_MAX_LINES,
  localparam int unsigned AGE_W    = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [AGE_W-1:0] touch_way_i,
  input  logic             fill_i,
  input  logic [AGE_W-1:0] fill_way_i,
  input  logic [WAYS-1:0]  line_ins_i,
  input  logic [WAYS-1:0]  line_evt_i,
  input  logic             req_i,
  output logic [AGE_W-1:0] victim_o,
  output logic             victim_vld_o
);
  logic [WAYS-1:0]            valid_q;
  logic [WAYS-1:0][AGE_W-1:0] age;
  logic [WAYS-1:0][CNT_W-1:0] cnt;
  logic [AGE_W-1:0]           pick_way, upd_way;
  logic                       upd;

  // fill outranks touch for recency
  assign upd     = fill_i | touch_i;
  assign upd_way = fill_i ? fill_way_i : touch_way_i;

  vsel_age_track #(.WAYS(WAYS)) u_age (
    .clk_i, .rst_ni, .upd_i(upd), .upd_way_i(upd_way), .age_o(age)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_cnt
    vsel_line_cnt #(.CNT_W(CNT_W), .MAX_LINES(MAX_LINES)) u_cnt (
      .clk_i, .rst_ni,
      .clr_i(fill_i && fill_way_i == AGE_W'(w)),
      .inc_i(line_ins_i[w]),
      .dec_i(line_evt_i[w]),
      .cnt_o(cnt[w])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     valid_q <= '0;
    else if (fill_i) valid_q[fill_way_i] <= 1'b1;
  end

  vsel_pick #(.WAYS(WAYS), .CAND(CAND), .CNT_W(CNT_W)) u_pick (
    .valid_i(valid_q), .age_i(age), .cnt_i(cnt), .way_o(pick_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_o     <= '0;
      victim_vld_o <= 1'b0;
    end else begin
      victim_vld_o <= req_i;
      if (req_i) victim_o <= pick_way;
    end
  end

  assert_vld_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> victim_vld_o);
  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!victim_vld_o && $stable(victim_o)));
  assert_invalid_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&valid_q) |-> !valid_q[pick_way]);
  assert_old_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_q) |-> age[pick_way] >= AGE_W'(WAYS - CAND));
  assert_fill_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> valid_q[$past(fill_way_i)]);
endmodule

// File: tb/tb_lru_lad_victim_sel.sv
`timescale 1ns/1ps
module tb_lru_lad_victim_sel;
  localparam int WAYS = 8, CAND = 4, MAXL = 64;

  logic       clk = 0, rst_n = 0;
  logic       touch = 0, fill = 0, req = 0;
  logic [2:0] touch_way = 0, fill_way = 0;
  logic [7:0] ins = 0, evt = 0;
  logic [2:0] victim;
  logic       vld;

  lru_lad_victim_sel dut (
    .clk_i(clk), .rst_ni(rst_n), .touch_i(touch), .touch_way_i(touch_way),
    .fill_i(fill), .fill_way_i(fill_way), .line_ins_i(ins), .line_evt_i(evt),
    .req_i(req), .victim_o(victim), .victim_vld_o(vld)
  );

  always #10 clk = ~clk;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string cur_tag = "R1";

  // reference model: recency as a queue, most recent first
  int m_order[$];
  bit m_valid[WAYS];
  int m_cnt[WAYS];
  int exp_victim;
  bit exp_vld;

  function automatic int model_pick();
    for (int w = 0; w < WAYS; w++) if (!m_valid[w]) return w;
    begin
      int best = m_order[WAYS-1];
      for (int p = WAYS - 2; p >= WAYS - CAND; p--)
        if (m_cnt[m_order[p]] < m_cnt[best]) best = m_order[p];
      return best;
    end
  endfunction

  function automatic void model_touch(int w);
    for (int p = 0; p < m_order.size(); p++)
      if (m_order[p] == w) begin m_order.delete(p); break; end
    m_order.push_front(w);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_order.delete();
      for (int w = 0; w < WAYS; w++) begin
        m_order.push_back(w); m_valid[w] = 0; m_cnt[w] = 0;
      end
      exp_victim = 0; exp_vld = 0;
    end else begin
      exp_vld = req;
      if (req) exp_victim = model_pick();
      for (int w = 0; w < WAYS; w++) begin
        if (ins[w] && !evt[w] && m_cnt[w] < MAXL) m_cnt[w]++;
        if (evt[w] && !ins[w] && m_cnt[w] > 0)    m_cnt[w]--;
      end
      if (fill) begin
        m_valid[fill_way] = 1; m_cnt[fill_way] = 0; model_touch(int'(fill_way));
      end else if (touch) model_touch(int'(touch_way));
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(vld === exp_vld, "victim_vld_o", int'(vld), int'(exp_vld));
    chk(victim === 3'(exp_victim), "victim_o", int'(victim), exp_victim);
  end

  task automatic step();
    @(posedge clk); #2;
    touch = 0; fill = 0; req = 0; ins = 0; evt = 0;
  endtask
  task automatic do_fill(int w);   fill = 1; fill_way = 3'(w); step(); endtask
  task automatic do_touch(int w);  touch = 1; touch_way = 3'(w); step(); endtask
  task automatic do_req();         req = 1; step(); endtask
  task automatic do_ins(int w, int n);
    for (int k = 0; k < n; k++) begin ins[w] = 1; step(); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk(vld === 1'b0, "reset victim_vld_o", int'(vld), 0);
    chk(victim === 3'd0, "reset victim_o", int'(victim), 0);
    #1 rst_n = 1;
    @(posedge clk); #2;
    do_req(); step();

    cur_tag = "R3";
    do_fill(0); do_fill(1); do_fill(2); do_fill(5);
    do_req(); step();          // expect way 3

    cur_tag = "R4";
    do_fill(3); do_fill(4); do_fill(6); do_fill(7);
    do_req(); step();

    cur_tag = "R8";            // refill in order 0..7, then shape counts
    for (int w = 0; w < WAYS; w++) do_fill(w);
    do_ins(0, 3); do_ins(1, 1); do_ins(2, 1); do_ins(3, 2);
    do_req(); step();          // way1: count tie with way2, older

    cur_tag = "R7";            // way4 holds 0 lines but is too young
    do_req(); step();

    cur_tag = "R5";
    do_touch(1); do_req(); step();   // way4 enters window with 0 lines

    cur_tag = "R6";
    do_ins(4, 70);             // saturate at 64
    for (int k = 0; k < 64; k++) begin evt[4] = 1; step(); end
    do_req(); step();          // way4 back to 0
    ins[4] = 1; evt[4] = 1; step(); do_req(); step();
    for (int k = 0; k < 3; k++) begin evt[0] = 1; evt[2] = 1; step(); end
    do_req(); step();

    cur_tag = "R9";
    fill = 1; fill_way = 3'd2; touch = 1; touch_way = 3'd6; ins[2] = 1; step();
    do_req(); step();

    cur_tag = "R2";
    for (int k = 0; k < 3000; k++) begin
      touch = ($urandom_range(0, 3) == 0); touch_way = 3'($urandom_range(0, 7));
      fill  = ($urandom_range(0, 15) == 0); fill_way = 3'($urandom_range(0, 7));
      ins   = 8'($urandom) & 8'($urandom);
      evt   = 8'($urandom) & 8'($urandom) & 8'($urandom);
      req   = ($urandom_range(0, 2) == 0);
      @(posedge clk); #2;
    end
    step(); step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule